// File: doc/BRIEF.md
# Event-Controlled Chainable Timer

This block holds two counters, each `CNT_W` bits wide (16 by default). Each counter can run on its own with its own settings. The two can also be linked into one counter of twice the width. Three events control each counter. A begin event starts it running, a clear event returns its count to zero, and a halt event stops it. Each event takes its source from one of four choices: never, every cycle, an edge on a selected trigger pin, or the counter reaching its period register. These settings let the same hardware act as a free-running counter, a counter that rolls over at a programmed limit, a one-shot, or a retriggerable monostable.

The counters run on their own count clock, which may be unrelated to the bus clock. Software works through a small register bus clocked by the bus clock. To read a running count, software requests a snapshot. The snapshot copies both counters in the same count cycle and passes the copy across the clock boundary with a toggle handshake. The two halves that are read back therefore always come from one instant.

Top module: `evt_timer`

## Requirements
- R1: After reset, every register read returns 0, both counts are 0 and `periodHit` is low.
- R2: The begin-event source field takes four codes: 0 never, 1 every cycle, 2 trigger edge, 3 period match. While a counter is running and enabled, its count rises by one on each count clock. With source 0 the counter never starts.
- R3: A clear event sets the count to zero on the next count clock and leaves the run state unchanged.
- R4: A halt event stops the counter, and the count holds its value until a later begin event.
- R5: If clear and halt occur in the same cycle, the halt is ignored. If halt and begin occur in the same cycle, the begin is ignored.
- R6: Trigger pins are synchronized to the count clock and edge-detected. Configuration bit 13 picks the falling edge (1) or the rising edge (0). A 2-bit select per event picks the pin. Edges on pins that are not selected have no effect.
- R7: `periodHit[m]` is high while module m is running and its count equals its period. With the clear event sourced from period match, the counter repeats every period+1 count clocks.
- R8: With begin every cycle and halt on period match, the counter stops and holds exactly at the period value.
- R9: With begin and clear both on a trigger edge and halt on match, each edge restarts the count from zero, and the count then holds at the period.
- R10: Configuration bit 14 of module 0 links the modules. Module 1 then counts each time module 0 wraps from its maximum value. Module 0's events control both modules, and the match compares the full double-width value.
- R11: When not linked, the two modules count with separate settings at the same time.
- R12: A write to address 4 requests a snapshot. Bit 0 of address 4 reads 1 while the request is pending. Addresses 5 and 6 return module 0 and module 1 counts taken in one count cycle, so successive linked snapshots never go backwards.
- R13: Configuration bit 0 clear (disabled) stops counting, whatever the begin source. Register map: 0 config 0, 1 period 0, 2 config 1, 3 period 1. Config fields: [2:1] begin source, [4:3] clear source, [6:5] halt source, [8:7]/[10:9]/[12:11] their pin selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busClk | input | 1 | Register bus clock |
| busRstN | input | 1 | Active-low reset, bus domain |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register word address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, combinational from address |
| cntClk | input | 1 | Count clock, may be asynchronous to busClk |
| cntRstN | input | 1 | Active-low reset, count domain |
| trigIn | input | TRIG_N | Asynchronous trigger pins |
| periodHit | output | 2 | Per-module period match while running, count domain |

## Verification
The assertions assume that configuration and period registers change only while the affected module is disabled or about to be cleared. Under that assumption the strobes seen in the count domain are coherent from one cycle to the next. They also assume that trigger pins hold each level for several count clocks. The bench meets these assumptions by clearing a module and waiting a few count clocks before every reconfiguration. It also holds each trigger level for four count clocks, and it issues snapshot requests only after the previous one has completed.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CNT_W  = 16;
  localparam int MOD_N  = 2;
  localparam int TRIG_N = 4;
  localparam int TSEL_W = $clog2(TRIG_N);
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 3;

  typedef enum logic [1:0] {
    SRC_OFF    = 2'd0,
    SRC_ALWAYS = 2'd1,
    SRC_TRIG   = 2'd2,
    SRC_MATCH  = 2'd3
  } src_e;

  typedef struct packed {
    logic              chain;
    logic              edgeFall;
    logic [TSEL_W-1:0] haltSel;
    logic [TSEL_W-1:0] clearSel;
    logic [TSEL_W-1:0] beginSel;
    src_e              haltSrc;
    src_e              clearSrc;
    src_e              beginSrc;
    logic              enable;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  typedef struct packed {
    logic clr;
    logic adv;
  } strobe_t;
endpackage

// File: rtl/tmr_bus.sv
module tmr_bus
  import tmr_pkg::*;
(
  input  logic              busClk,
  input  logic              busRstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [BUS_W-1:0]  regWdata,
  output logic [BUS_W-1:0]  regRdata,
  output cfg_t              cfgArr [MOD_N],
  output logic [CNT_W-1:0]  perArr [MOD_N],
  output logic              reqTgl,
  input  logic              ackTgl,
  input  logic [CNT_W-1:0]  snapCnt [MOD_N],
  output logic [CNT_W-1:0]  busSnap [MOD_N],
  output logic              busy
);
  localparam logic [ADDR_W-1:0] ADDR_SNAP = ADDR_W'(2 * MOD_N);

  logic ackS1, ackS2, ackPrev;

  always_ff @(posedge busClk or negedge busRstN) begin
    if (!busRstN) begin
      for (int i = 0; i < MOD_N; i++) begin
        cfgArr[i] <= '0;
        perArr[i] <= '0;
      end
    end else if (regWe) begin
      for (int i = 0; i < MOD_N; i++) begin
        if (regAddr == ADDR_W'(2 * i))     cfgArr[i] <= cfg_t'(regWdata[CFG_W-1:0]);
        if (regAddr == ADDR_W'(2 * i + 1)) perArr[i] <= regWdata[CNT_W-1:0];
      end
    end
  end

  assign busy = (reqTgl != ackPrev);

  always_ff @(posedge busClk or negedge busRstN) begin
    if (!busRstN) begin
      reqTgl  <= 1'b0;
      ackS1   <= 1'b0;
      ackS2   <= 1'b0;
      ackPrev <= 1'b0;
      for (int i = 0; i < MOD_N; i++) busSnap[i] <= '0;
    end else begin
      ackS1   <= ackTgl;
      ackS2   <= ackS1;
      ackPrev <= ackS2;
      if (ackS2 != ackPrev) begin
        for (int i = 0; i < MOD_N; i++) busSnap[i] <= snapCnt[i];
      end
      if (regWe && regAddr == ADDR_SNAP && !busy) reqTgl <= ~reqTgl;
    end
  end

  always_comb begin
    regRdata = '0;
    for (int i = 0; i < MOD_N; i++) begin
      if (regAddr == ADDR_W'(2 * i))     regRdata = {{(BUS_W-CFG_W){1'b0}}, cfgArr[i]};
      if (regAddr == ADDR_W'(2 * i + 1)) regRdata = {{(BUS_W-CNT_W){1'b0}}, perArr[i]};
      if (regAddr == ADDR_W'(2 * MOD_N + 1 + i)) regRdata = {{(BUS_W-CNT_W){1'b0}}, busSnap[i]};
    end
    if (regAddr == ADDR_SNAP) regRdata = {{(BUS_W-1){1'b0}}, busy};
  end
endmodule

// File: rtl/tmr_trig.sv
module tmr_trig
  import tmr_pkg::*;
(
  input  logic              cntClk,
  input  logic              cntRstN,
  input  logic [TRIG_N-1:0] trigIn,
  output logic [TRIG_N-1:0] riseEv,
  output logic [TRIG_N-1:0] fallEv
);
  logic [TRIG_N-1:0] s1, s2, s3;

  always_ff @(posedge cntClk or negedge cntRstN) begin
    if (!cntRstN) begin
      s1 <= '0;
      s2 <= '0;
      s3 <= '0;
    end else begin
      s1 <= trigIn;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign riseEv = s2 & ~s3;
  assign fallEv = ~s2 & s3;
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
(
  input  logic              cntClk,
  input  logic              cntRstN,
  input  cfg_t              cfg,
  input  logic [TRIG_N-1:0] riseEv,
  input  logic [TRIG_N-1:0] fallEv,
  input  logic              matchRaw,
  output strobe_t           stb,
  output logic              run
);
  logic [TRIG_N-1:0] edgeV;
  logic beginEv, clearEv, haltEv, haltEff, beginEff;

  function automatic logic pickEv(src_e s, logic [TSEL_W-1:0] sel,
                                  logic [TRIG_N-1:0] ev, logic m);
    case (s)
      SRC_OFF:    return 1'b0;
      SRC_ALWAYS: return 1'b1;
      SRC_TRIG:   return ev[sel];
      default:    return m;
    endcase
  endfunction

  always_comb begin
    edgeV    = cfg.edgeFall ? fallEv : riseEv;
    beginEv  = pickEv(cfg.beginSrc, cfg.beginSel, edgeV, matchRaw);
    clearEv  = pickEv(cfg.clearSrc, cfg.clearSel, edgeV, matchRaw);
    haltEv   = pickEv(cfg.haltSrc,  cfg.haltSel,  edgeV, matchRaw);
    haltEff  = haltEv && !clearEv;
    beginEff = beginEv && !haltEff;
    stb.clr  = clearEv;
    stb.adv  = run && cfg.enable && !clearEv && !haltEff;
  end

  always_ff @(posedge cntClk or negedge cntRstN) begin
    if (!cntRstN)        run <= 1'b0;
    else if (!cfg.enable) run <= 1'b0;
    else if (haltEff)    run <= 1'b0;
    else if (beginEff)   run <= 1'b1;
  end
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
(
  input  logic             cntClk,
  input  logic             cntRstN,
  input  strobe_t          stb [MOD_N],
  input  logic [MOD_N-1:0] run,
  input  logic             chain,
  input  logic [CNT_W-1:0] perArr [MOD_N],
  input  logic             reqTgl,
  output logic             ackTgl,
  output logic [CNT_W-1:0] snapCnt [MOD_N],
  output logic [CNT_W-1:0] cnt [MOD_N],
  output logic [MOD_N-1:0] matchRaw,
  output logic [MOD_N-1:0] periodHit
);
  strobe_t eff [MOD_N];
  logic lowWrap, reqS1, reqS2, reqPrev;

  assign lowWrap = (cnt[0] == {CNT_W{1'b1}});

  always_comb begin
    eff[0] = stb[0];
    if (chain) begin
      eff[1].clr = stb[0].clr;
      eff[1].adv = stb[0].adv && lowWrap;
    end else begin
      eff[1] = stb[1];
    end
    matchRaw[1] = (cnt[1] == perArr[1]);
    matchRaw[0] = (cnt[0] == perArr[0]) && (!chain || matchRaw[1]);
    periodHit[0] = matchRaw[0] && run[0];
    periodHit[1] = !chain && matchRaw[1] && run[1];
  end

  for (genvar i = 0; i < MOD_N; i++) begin : g_cnt
    always_ff @(posedge cntClk or negedge cntRstN) begin
      if (!cntRstN)        cnt[i] <= '0;
      else if (eff[i].clr) cnt[i] <= '0;
      else if (eff[i].adv) cnt[i] <= cnt[i] + 1'b1;
    end
  end

  always_ff @(posedge cntClk or negedge cntRstN) begin
    if (!cntRstN) begin
      reqS1   <= 1'b0;
      reqS2   <= 1'b0;
      reqPrev <= 1'b0;
      ackTgl  <= 1'b0;
      for (int i = 0; i < MOD_N; i++) snapCnt[i] <= '0;
    end else begin
      reqS1   <= reqTgl;
      reqS2   <= reqS1;
      reqPrev <= reqS2;
      if (reqS2 != reqPrev) begin
        for (int i = 0; i < MOD_N; i++) snapCnt[i] <= cnt[i];
        ackTgl <= reqS2;
      end
    end
  end
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import tmr_pkg::*;
(
  input  logic              busClk,
  input  logic              busRstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [BUS_W-1:0]  regWdata,
  output logic [BUS_W-1:0]  regRdata,
  input  logic              cntClk,
  input  logic              cntRstN,
  input  logic [TRIG_N-1:0] trigIn,
  output logic [MOD_N-1:0]  periodHit
);
  cfg_t              cfgArr [MOD_N];
  logic [CNT_W-1:0]  perArr [MOD_N];
  logic [CNT_W-1:0]  snapCnt [MOD_N];
  logic [CNT_W-1:0]  busSnap [MOD_N];
  logic [CNT_W-1:0]  cnt [MOD_N];
  strobe_t           stb [MOD_N];
  logic [MOD_N-1:0]  run, matchRaw;
  logic [TRIG_N-1:0] riseEv, fallEv;
  logic              reqTgl, ackTgl, busy;

  tmr_bus u_bus (
    .busClk, .busRstN, .regWe, .regAddr, .regWdata, .regRdata,
    .cfgArr, .perArr, .reqTgl, .ackTgl, .snapCnt, .busSnap, .busy
  );

  tmr_trig u_trig (.cntClk, .cntRstN, .trigIn, .riseEv, .fallEv);

  for (genvar i = 0; i < MOD_N; i++) begin : g_ctrl
    tmr_ctrl u_ctrl (
      .cntClk, .cntRstN, .cfg(cfgArr[i]), .riseEv, .fallEv,
      .matchRaw(matchRaw[i]), .stb(stb[i]), .run(run[i])
    );
  end

  tmr_datapath u_dp (
    .cntClk, .cntRstN, .stb, .run, .chain(cfgArr[0].chain), .perArr,
    .reqTgl, .ackTgl, .snapCnt, .cnt, .matchRaw, .periodHit
  );
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk
  import tmr_pkg::*;
(
  input logic              cntClk,
  input logic              cntRstN,
  input logic              busClk,
  input logic              busRstN,
  input logic              chain,
  input strobe_t           stb0,
  input logic [CNT_W-1:0]  cnt0,
  input logic [CNT_W-1:0]  cnt1,
  input logic              busy,
  input logic              regWe,
  input logic [ADDR_W-1:0] regAddr,
  input logic [CNT_W-1:0]  snapLo,
  input logic [CNT_W-1:0]  snapHi
);
  assert_clear_zero_R3: assert property (@(posedge cntClk) disable iff (!cntRstN)
    stb0.clr |=> cnt0 == '0);

  assert_step_one_R2: assert property (@(posedge cntClk) disable iff (!cntRstN)
    (stb0.adv && !stb0.clr) |=> cnt0 == CNT_W'($past(cnt0) + 1'b1));

  assert_hold_R4: assert property (@(posedge cntClk) disable iff (!cntRstN)
    (!stb0.adv && !stb0.clr) |=> $stable(cnt0));

  assert_chain_carry_R10: assert property (@(posedge cntClk) disable iff (!cntRstN)
    (chain && !stb0.clr && !(stb0.adv && cnt0 == {CNT_W{1'b1}})) |=> $stable(cnt1));

  assert_snap_steady_R12: assert property (@(posedge busClk) disable iff (!busRstN)
    (!busy && !(regWe && regAddr == ADDR_W'(2 * MOD_N))) |=> ($stable(snapLo) && $stable(snapHi)));
endmodule

bind evt_timer tmr_chk u_chk (
  .cntClk(cntClk), .cntRstN(cntRstN), .busClk(busClk), .busRstN(busRstN),
  .chain(cfgArr[0].chain), .stb0(stb[0]), .cnt0(cnt[0]), .cnt1(cnt[1]),
  .busy(busy), .regWe(regWe), .regAddr(regAddr),
  .snapLo(busSnap[0]), .snapHi(busSnap[1])
);

// File: tb/evt_timer_tb.sv
module evt_timer_tb;
  import tmr_pkg::*;

  localparam logic [1:0] OFF = 2'd0, ALW = 2'd1, TRG = 2'd2, MAT = 2'd3;

  logic busClk = 0, cntClk = 0, busRstN = 0, cntRstN = 0, regWe = 0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [BUS_W-1:0]  regWdata = '0;
  logic [BUS_W-1:0]  regRdata;
  logic [TRIG_N-1:0] trigIn = '0;
  logic [MOD_N-1:0]  periodHit;
  int checks = 0, errors = 0;

  always #4 busClk = ~busClk;
  always #3 cntClk = ~cntClk;

  evt_timer u_dut (.*);

  function automatic logic [31:0] mk(bit en, logic [1:0] st, logic [1:0] rs, logic [1:0] sp,
                                     logic [1:0] sSel = 0, logic [1:0] rSel = 0,
                                     logic [1:0] pSel = 0, bit fall = 0, bit chain = 0);
    return {17'b0, chain, fall, pSel, rSel, sSel, sp, rs, st, en};
  endfunction

  function automatic int expGap(int p);
    return p + 1;
  endfunction

  task automatic chkEq(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chkCond(string req, bit ok, logic [31:0] act, string expTxt);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected %s", req, act, expTxt);
    end
  endtask

  task automatic waitCnt(int n);
    repeat (n) @(posedge cntClk);
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge busClk);
    regWe = 1; regAddr = ADDR_W'(a); regWdata = d;
    @(negedge busClk);
    regWe = 0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge busClk);
    regAddr = ADDR_W'(a);
    #1 d = regRdata;
  endtask

  task automatic snap(output logic [31:0] lo, output logic [31:0] hi);
    logic [31:0] v;
    wr(4, 0);
    for (int k = 0; k < 100; k++) begin
      rd(4, v);
      if (!v[0]) break;
    end
    rd(5, lo);
    rd(6, hi);
  endtask

  task automatic clrMod(int m);
    wr(2 * m, mk(0, OFF, ALW, OFF));
    waitCnt(6);
    wr(2 * m, 0);
    waitCnt(4);
  endtask

  task automatic pulse(int idx);
    trigIn[idx] = 1'b1; waitCnt(4);
    trigIn[idx] = 1'b0; waitCnt(4);
  endtask

  task automatic gap(int m, output int g);
    do @(negedge cntClk); while (!periodHit[m]);
    g = 0;
    do begin @(negedge cntClk); g++; end while (!periodHit[m]);
  endtask

  initial begin
    repeat (180000) @(posedge busClk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, a, b, c, d;
    logic [31:0] prev;
    int g, p, seedV;
    seedV = $urandom(32'd2718);
    repeat (10) @(negedge busClk);
    busRstN = 1; cntRstN = 1;
    waitCnt(4);

    // R1 reset state
    for (int i = 0; i < 7; i++) begin
      rd(i, v);
      chkEq("R1 register reset", v, 0);
    end
    chkEq("R1 periodHit reset", {30'b0, periodHit}, 0);

    // R2 source never: no start
    wr(0, mk(1, OFF, OFF, OFF));
    waitCnt(50);
    snap(a, b);
    chkEq("R2 begin source off", a, 0);
    // R13 disabled with begin every cycle
    wr(0, mk(0, ALW, OFF, OFF));
    waitCnt(50);
    snap(a, b);
    chkEq("R13 disabled no count", a, 0);

    // R2 free run
    wr(0, mk(1, ALW, OFF, OFF));
    waitCnt(30);
    snap(a, b);
    waitCnt(20);
    snap(c, d);
    chkCond("R2 count advances", (c - a) >= 20 && (c - a) < 200, c - a, "in [20,200)");
    // R13 disable freezes
    wr(0, mk(0, ALW, OFF, OFF));
    waitCnt(6);
    snap(a, b);
    waitCnt(30);
    snap(c, d);
    chkEq("R13 disable holds count", c, a);

    // R7 rollover, directed and random periods
    for (int it = 0; it < 7; it++) begin
      p = (it == 0) ? 5 : 1 + int'($urandom_range(39));
      clrMod(0);
      wr(1, p);
      wr(0, mk(1, ALW, MAT, OFF));
      gap(0, g);
      chkEq("R7 rollover period", g, expGap(p));
      snap(a, b);
      chkCond("R7 count within period", a <= p, a, "<= period");
    end

    // R8 one-shot
    clrMod(0);
    wr(1, 25);
    wr(0, mk(1, ALW, OFF, MAT));
    waitCnt(60);
    snap(a, b);
    chkEq("R8 one-shot stops at period", a, 25);
    waitCnt(20);
    snap(a, b);
    chkEq("R8 one-shot stays", a, 25);

    // R9 retriggerable monostable
    clrMod(0);
    wr(1, 30);
    wr(0, mk(1, TRG, TRG, MAT, 0, 0));
    waitCnt(20);
    snap(a, b);
    chkEq("R9 idle before trigger", a, 0);
    pulse(0);
    waitCnt(60);
    snap(a, b);
    chkEq("R9 holds at period", a, 30);
    pulse(0);
    snap(a, b);
    chkCond("R9 retrigger restarts", a < 30, a, "< 30");
    waitCnt(60);
    snap(a, b);
    chkEq("R9 holds again", a, 30);

    // R6 falling edge and pin select
    clrMod(0);
    wr(0, mk(1, TRG, OFF, OFF, 2, 0, 0, 1));
    trigIn[2] = 1'b1;
    waitCnt(20);
    snap(a, b);
    chkEq("R6 rising ignored when falling selected", a, 0);
    trigIn[2] = 1'b0;
    waitCnt(20);
    snap(a, b);
    chkCond("R6 falling edge starts", a > 0, a, "> 0");
    clrMod(0);
    wr(0, mk(1, TRG, OFF, OFF, 1));
    pulse(3);
    waitCnt(10);
    snap(a, b);
    chkEq("R6 unselected pin ignored", a, 0);

    // R5 clear beats halt
    clrMod(0);
    wr(0, mk(1, ALW, TRG, TRG, 0, 0, 0));
    waitCnt(200);
    pulse(0);
    waitCnt(20);
    snap(a, b);
    waitCnt(20);
    snap(c, d);
    chkCond("R5 clear applied", a < 60, a, "< 60");
    chkCond("R5 halt suppressed by clear", c > a, c, "> first snapshot");
    // R5 halt beats begin
    clrMod(0);
    wr(0, mk(1, TRG, OFF, TRG, 1, 0, 1));
    pulse(1);
    waitCnt(30);
    snap(a, b);
    chkEq("R5 begin suppressed by halt", a, 0);

    // R3 clear keeps run state
    clrMod(0);
    wr(0, mk(1, ALW, TRG, OFF, 0, 2, 0));
    waitCnt(300);
    pulse(2);
    snap(a, b);
    chkCond("R3 clear to zero while running", a < 40, a, "< 40");

    // R11 independent modules
    clrMod(0); clrMod(1);
    wr(1, 4); wr(3, 9);
    wr(0, mk(1, ALW, MAT, OFF));
    wr(2, mk(1, ALW, OFF, MAT));
    gap(0, g);
    chkEq("R11 module 0 rollover", g, expGap(4));
    waitCnt(40);
    snap(a, b);
    chkEq("R11 module 1 one-shot", b, 9);
    chkCond("R11 module 0 in range", a <= 4, a, "<= 4");

    // R10 chained one-shot with R12 coherent snapshots
    clrMod(0); clrMod(1);
    wr(3, 1); wr(1, 3);
    wr(0, mk(1, ALW, OFF, MAT, 0, 0, 0, 0, 1));
    prev = 0;
    for (int i = 0; i < 22; i++) begin
      waitCnt(3000);
      snap(a, b);
      v = {b[15:0], a[15:0]};
      chkCond("R12 linked snapshot monotonic", v >= prev, v, ">= previous");
      prev = v;
    end
    waitCnt(1000);
    snap(a, b);
    chkEq("R10 linked final value", {b[15:0], a[15:0]}, 32'h0001_0003);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule